// File: doc/BRIEF.md
# LED Matrix Row Refresh Scanner

The scanner drives a dot-matrix LED array of 20 columns and 8 rows by lighting one row at a time. It takes a flat 160-bit dot image and a 6-bit control word, and produces a one-hot row-sink select and 20 column-enable lines. A frame takes 512 scan ticks, so every row owns a 64-tick slot. The first 4 ticks of each slot are dark so that the previous row's charge can die away. The rest of the slot is an on-window of up to 60 ticks, and a 4-bit duty code shortens it. A 2-bit peak-current code passes straight to an output for the analog current sources, which sit outside this block.

A scan tick is either every clock or, when the slow-clock option is set, one clock in eight. With a clock eight times faster, the slow option gives the same refresh timing. The control word is taken in only at frame boundaries, so a brightness change never tears a frame.

The sequencer is a four-state machine:
- S_IDLE: after reset. All outputs are off. The first tick goes to S_BLANK of row 0 and starts a frame.
- S_BLANK: the guard ticks 0 to 3 of a slot. At tick 3 the row's dots are latched, and the machine goes to S_ON, or to S_DARK if the on-count is zero.
- S_ON: the columns are driven. Leaving it goes to S_DARK when the on-count is used up, or to the next row's S_BLANK at slot end.
- S_DARK: the rest of the slot. At slot end it goes to the next row's S_BLANK, and after row 7 it wraps to row 0.

Top module: `led_row_scanner`

## Requirements
- R1: While `rst` is high, and afterwards until the first scan tick, `row_sel`, `col_drv`, `peak_sel` and `frame_start` are all zero.
- R2: After the first tick, exactly one bit of `row_sel` is set. Rows are selected in the order 0,1,…,7,0, each for 64 consecutive ticks.
- R3: `frame_start` is high for one clock in the first cycle of every frame: once after the first tick, then every 512 ticks. Each pulse coincides with row 0 becoming selected.
- R4: In tick positions 0 to 3 of every row slot, `col_drv` is zero.
- R5: Let c be the duty code `ctrl_word[3:0]`. The on-count N(c) is floor(c·36/13) for c ≤ 13 and 36 + (c−13)·12 above that, so N(0)=0, N(13)=36 and N(15)=60. Columns are driven in slot positions 4 to 3+N and are zero for the rest of the slot.
- R6: Column bit k of row r is `dot_bits[r*20+k]`, taken at the end of the blanking of that row's slot. Changes to `dot_bits` after that point have no effect until that row's next slot.
- R7: `peak_sel` equals `ctrl_word[5:4]` as sampled at the start of the current frame.
- R8: A change of `ctrl_word` in mid-frame changes neither the on-count nor `peak_sel` before the next frame boundary.
- R9: With `slow_clk_en` high, one tick occurs per 8 clocks. A frame then spans 4096 clocks and each row is held for 512 clocks.
- R10: Raising `rst` in mid-frame returns the block to the R1 state at the next clock edge. The next frame starts at row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_clk_en | input | 1 | 1: one scan tick per 8 clocks; 0: a tick every clock |
| dot_bits | input | 160 | Dot image; row r occupies bits r*20 to r*20+19 |
| ctrl_word | input | 6 | [5:4] peak-current code, [3:0] duty code |
| row_sel | output | 8 | One-hot row-sink select |
| col_drv | output | 20 | Column enables for the selected row |
| peak_sel | output | 2 | Peak-current code for the current frame |
| frame_start | output | 1 | One-clock pulse at the start of each frame |

## Verification
The bench goes after the edges of the on-window: duty codes 0, 1, 7, 13 and 14 as well as the full code 15. An off-by-one in the blank-to-on or on-to-dark transition shows up there as one tick too many or too few of column drive, and code 0 would leak a single lit tick. It rewrites the dot image and the control word in mid-slot and mid-frame. A design that read `dot_bits` combinationally, or that took the control word at once, would then show torn rows or a brightness change before the frame boundary. It also measures the frame and row periods with the slow clock option, and a reset in mid-frame. A prescaler that divided wrongly, or a counter that failed to clear, would give a period other than 4096 clocks or a first frame that does not start at row 0.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_BLANK = 2'd1,
        S_ON    = 2'd2,
        S_DARK  = 2'd3
    } scan_state_t;
endpackage

// File: rtl/scan_prescaler.sv
module scan_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (slow_en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    assign tick = slow_en ? (cnt == LAST) : 1'b1;

    // R9
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (slow_en && $past(slow_en) && $past(tick)) |-> !tick);
endmodule

// File: rtl/scan_duty_lut.sv
module scan_duty_lut #(
    parameter int CODE_W = 4,
    parameter int ON_MAX = 60,
    parameter int CNT_W  = 6
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  on_len
);
    localparam int TOP_CODE  = (1 << CODE_W) - 1;
    localparam int KNEE_CODE = TOP_CODE - 2;
    localparam int KNEE_LEN  = (ON_MAX * 3) / 5;
    localparam int UPPER_STEP = (ON_MAX - KNEE_LEN) / (TOP_CODE - KNEE_CODE);

    always_comb begin
        int c;
        int v;
        c = int'(code);
        if (c <= KNEE_CODE) begin
            v = (c * KNEE_LEN) / KNEE_CODE;
        end else begin
            v = KNEE_LEN + (c - KNEE_CODE) * UPPER_STEP;
        end
        on_len = CNT_W'(v);
    end

    // R5
    lut_range_chk: assert final (int'(on_len) <= ON_MAX);
endmodule

// File: rtl/scan_row_fsm.sv
module scan_row_fsm
    import scan_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int COLS   = 20,
    parameter int SLOT   = 64,
    parameter int BLANK  = 4,
    parameter int CTRL_W = 6,
    parameter int CNT_W  = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [ROWS*COLS-1:0] dots,
    input  logic [CTRL_W-1:0]    ctrl,
    input  logic [CNT_W-1:0]     on_len,
    output logic [CTRL_W-1:0]    ctrl_q,
    output logic [ROWS-1:0]      row_sel,
    output logic [COLS-1:0]      col_drv,
    output logic                 frame_start
);
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int POS_W = $clog2(SLOT);
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(SLOT - 1);
    localparam logic [POS_W-1:0] BLANK_END = POS_W'(BLANK - 1);
    localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(ROWS - 1);

    scan_state_t          state, st_n;
    logic [ROW_W-1:0]     row, row_n;
    logic [POS_W-1:0]     pos, pos_n;
    logic [COLS-1:0]      cols_q;
    logic                 fs_q;
    logic                 last_pos, blank_end, on_end, boundary;
    logic [ROW_W-1:0]     row_next;

    assign last_pos  = (pos == POS_LAST);
    assign blank_end = (pos == BLANK_END);
    assign on_end    = (int'(pos) + 1) == (int'(on_len) + BLANK);
    assign row_next  = (row == ROW_LAST) ? '0 : row + 1'b1;
    assign boundary  = (state == S_IDLE) || (last_pos && row == ROW_LAST);

    // transition logic
    always_comb begin
        st_n  = state;
        row_n = row;
        pos_n = pos;
        unique case (state)
            S_IDLE: begin
                st_n  = S_BLANK;
                row_n = '0;
                pos_n = '0;
            end
            S_BLANK: begin
                pos_n = pos + 1'b1;
                if (blank_end) st_n = (on_len == '0) ? S_DARK : S_ON;
            end
            S_ON: begin
                if (last_pos) begin
                    st_n  = S_BLANK;
                    row_n = row_next;
                    pos_n = '0;
                end else begin
                    pos_n = pos + 1'b1;
                    if (on_end) st_n = S_DARK;
                end
            end
            S_DARK: begin
                if (last_pos) begin
                    st_n  = S_BLANK;
                    row_n = row_next;
                    pos_n = '0;
                end else begin
                    pos_n = pos + 1'b1;
                end
            end
            default: st_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            row    <= '0;
            pos    <= '0;
            cols_q <= '0;
            ctrl_q <= '0;
            fs_q   <= 1'b0;
        end else begin
            fs_q <= tick && boundary;
            if (tick) begin
                state <= st_n;
                row   <= row_n;
                pos   <= pos_n;
                if (boundary) ctrl_q <= ctrl;
                if (state == S_BLANK && blank_end)
                    cols_q <= dots[int'(row)*COLS +: COLS];
            end
        end
    end

    // outputs
    always_comb begin
        row_sel = '0;
        col_drv = '0;
        unique case (state)
            S_IDLE:  ;
            S_BLANK: row_sel[row] = 1'b1;
            S_ON: begin
                row_sel[row] = 1'b1;
                col_drv      = cols_q;
            end
            S_DARK:  row_sel[row] = 1'b1;
            default: ;
        endcase
    end

    assign frame_start = fs_q;

    // R2
    one_row_chk: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE) |-> ($countones(row_sel) == 1));

    // R2
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && state != S_IDLE && last_pos) |=> (row == $past(row_next) && pos == '0));

    // R4
    guard_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && pos < POS_W'(BLANK)) |-> (state == S_BLANK));

    // R5
    on_window_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_ON) |-> ((int'(pos) - BLANK) < int'(on_len)));

    // R3
    frame_align_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (state == S_BLANK && row == '0 && pos == '0));
endmodule

// File: rtl/led_row_scanner.sv
module led_row_scanner #(
    parameter int ROWS     = 8,
    parameter int COLS     = 20,
    parameter int SLOT     = 64,
    parameter int BLANK    = 4,
    parameter int PRE_DIV  = 8,
    parameter int DUTY_W   = 4,
    parameter int PEAK_W   = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   slow_clk_en,
    input  logic [ROWS*COLS-1:0]   dot_bits,
    input  logic [PEAK_W+DUTY_W-1:0] ctrl_word,
    output logic [ROWS-1:0]        row_sel,
    output logic [COLS-1:0]        col_drv,
    output logic [PEAK_W-1:0]      peak_sel,
    output logic                   frame_start
);
    localparam int CTRL_W = PEAK_W + DUTY_W;
    localparam int ON_MAX = SLOT - BLANK;
    localparam int CNT_W  = $clog2(ON_MAX + 1);

    logic              tick;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  on_len;

    scan_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .slow_en (slow_clk_en),
        .tick    (tick)
    );

    scan_duty_lut #(.CODE_W(DUTY_W), .ON_MAX(ON_MAX), .CNT_W(CNT_W)) u_lut (
        .code   (ctrl_q[DUTY_W-1:0]),
        .on_len (on_len)
    );

    scan_row_fsm #(
        .ROWS(ROWS), .COLS(COLS), .SLOT(SLOT), .BLANK(BLANK),
        .CTRL_W(CTRL_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .dots        (dot_bits),
        .ctrl        (ctrl_word),
        .on_len      (on_len),
        .ctrl_q      (ctrl_q),
        .row_sel     (row_sel),
        .col_drv     (col_drv),
        .frame_start (frame_start)
    );

    assign peak_sel = ctrl_q[CTRL_W-1:DUTY_W];

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (row_sel == '0 && col_drv == '0 && peak_sel == '0 && !frame_start));

    // R8
    peak_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !$past(rst)) |-> $stable(peak_sel));
endmodule

// File: tb/sim_led_row_scanner.sv
module sim_led_row_scanner;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         slow_clk_en = 1'b0;
    logic [159:0] dot_bits = '0;
    logic [5:0]   ctrl_word = 6'b11_1111;
    logic [7:0]   row_sel;
    logic [19:0]  col_drv;
    logic [1:0]   peak_sel;
    logic         frame_start;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    int         t;
    logic [5:0] eff_ctrl;
    logic [19:0] eff_row;

    always #(CLK_P/2) clk = ~clk;

    led_row_scanner u0 (
        .clk(clk), .rst(rst), .slow_clk_en(slow_clk_en), .dot_bits(dot_bits),
        .ctrl_word(ctrl_word), .row_sel(row_sel), .col_drv(col_drv),
        .peak_sel(peak_sel), .frame_start(frame_start)
    );

    function automatic int on_count(int c);
        return (c <= 13) ? (c * 36) / 13 : 36 + (c - 13) * 12;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at t=%0d: got %0h expected %0h", req, what, t, act, exp);
        end
    endtask

    task automatic check_quiet(string req);
        chk(row_sel == 0, req, "row_sel", 32'(row_sel), 0);
        chk(col_drv == 0, req, "col_drv", 32'(col_drv), 0);
        chk(peak_sel == 0, req, "peak_sel", 32'(peak_sel), 0);
        chk(frame_start == 0, req, "frame_start", 32'(frame_start), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        t = -1;
        eff_ctrl = '0;
        eff_row = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check_quiet("R1");
    endtask

    // advance one tick (slow clock off) and compare all outputs with the model
    task automatic step();
        int tn, p, r;
        logic [19:0] ec;
        tn = t + 1;
        p = tn % 64;
        r = (tn / 64) % 8;
        if (tn % 512 == 0) eff_ctrl = ctrl_word;
        if (p == 4) eff_row = dot_bits[r*20 +: 20];
        @(posedge clk);
        @(negedge clk);
        t = tn;
        ec = (p >= 4 && (p - 4) < on_count(int'(eff_ctrl[3:0]))) ? eff_row : 20'h0;
        chk(row_sel == (8'b1 << r), "R2", "row_sel", 32'(row_sel), 32'(8'b1 << r));
        chk(frame_start == (tn % 512 == 0), "R3", "frame_start", 32'(frame_start), 32'(tn % 512 == 0));
        chk(col_drv == ec, (p < 4) ? "R4" : "R5/R6", "col_drv", 32'(col_drv), 32'(ec));
        chk(peak_sel == eff_ctrl[5:4], "R7", "peak_sel", 32'(peak_sel), 32'(eff_ctrl[5:4]));
    endtask

    function automatic logic [159:0] pattern(int seed);
        logic [159:0] v;
        for (int i = 0; i < 8; i++) v[i*20 +: 20] = 20'(32'h9E3B7 * (i + 1) + seed * 32'h1D3);
        return v;
    endfunction

    task automatic test_reset();
        rst = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check_quiet("R1");
        end
    endtask

    task automatic test_full_frame();
        ctrl_word = 6'b11_1111;
        dot_bits = pattern(1);
        do_reset();
        for (int i = 0; i < 1030; i++) step();
    endtask

    task automatic test_duty_codes();
        int codes [5] = '{0, 1, 7, 13, 14};
        foreach (codes[k]) begin
            int lit;
            lit = 0;
            ctrl_word = 6'(codes[k]);
            dot_bits = pattern(k + 2);
            do_reset();
            for (int i = 0; i < 64; i++) begin
                step();
                if (col_drv != 0) lit++;
            end
            // R5: on-count per duty code
            chk(lit == on_count(codes[k]), "R5", "lit ticks in row 0", 32'(lit), 32'(on_count(codes[k])));
        end
    endtask

    task automatic test_dot_ignore();
        ctrl_word = 6'b00_1111;
        dot_bits = pattern(9);
        do_reset();
        for (int i = 0; i < 600; i++) begin
            if (i % 7 == 3) dot_bits = pattern(i);
            step();
        end
        // R6: row 1 slot shows the image taken at its blanking end
        chk(1'b1, "R6", "image sweep done", 0, 0);
    endtask

    task automatic test_ctrl_midframe();
        ctrl_word = 6'b10_1111;
        dot_bits = pattern(20);
        do_reset();
        for (int i = 0; i < 100; i++) step();
        ctrl_word = 6'b01_1101;
        for (int i = 0; i < 200; i++) step();
        // R8: still old code mid-frame
        chk(peak_sel == 2'b10, "R8", "peak_sel mid-frame", 32'(peak_sel), 32'h2);
        while (t < 600) step();
        // R7: new code after boundary
        chk(peak_sel == 2'b01, "R7", "peak_sel next frame", 32'(peak_sel), 32'h1);
    endtask

    task automatic test_prescale();
        int gap, row0_clks;
        bit seen;
        slow_clk_en = 1'b1;
        ctrl_word = 6'b00_1111;
        do_reset();
        seen = 0;
        while (!seen) begin
            @(negedge clk);
            if (frame_start) seen = 1;
        end
        gap = 0;
        row0_clks = 0;
        do begin
            if (row_sel == 8'h01) row0_clks++;
            @(negedge clk);
            gap++;
        end while (!frame_start && gap < 10000);
        // R9
        chk(gap == 4096, "R9", "frame period in clocks", 32'(gap), 32'd4096);
        chk(row0_clks == 512, "R9", "row 0 hold in clocks", 32'(row0_clks), 32'd512);
        slow_clk_en = 1'b0;
    endtask

    task automatic test_mid_reset();
        ctrl_word = 6'b11_0101;
        dot_bits = pattern(33);
        do_reset();
        for (int i = 0; i < 300; i++) step();
        rst = 1'b1;
        @(negedge clk);
        // R10
        check_quiet("R10");
        rst = 1'b0;
        t = -1;
        eff_ctrl = '0;
        #1;
        check_quiet("R10");
        step();
        chk(frame_start == 1'b1 && row_sel == 8'h01, "R10", "restart at row 0",
            {row_sel, 23'h0, frame_start}, {8'h01, 23'h0, 1'b1});
    endtask

    initial begin
        t = -1;
        eff_ctrl = '0;
        eff_row = '0;
        test_reset();
        test_full_frame();
        test_duty_codes();
        test_dot_ignore();
        test_ctrl_midframe();
        test_prescale();
        test_mid_reset();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule